// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core takes next. It gathers events from three kinds of source. Seven external pins pass through a synchronizer and an edge detector. Nine internal peripheral strobes cover the serial, timer, second serial and converter events. One software-break strobe is raised by the core when it executes a break instruction. Every event sets a request bit. Maskable sources also have an enable bit.

The core tells the controller when it has reached an instruction boundary. At that point the controller looks at all pending sources, applies the enable bits and the core's global interrupt-disable flag, and picks the single highest-priority candidate. The break request ignores every mask. The next cycle it gives the core three things: a one-cycle take strobe, which tells the core to push the program counter and the status register; a one-cycle strobe that tells the core to set its disable flag; and the address of the low byte of the winner's two-byte vector. In the same edge, only the winner's request bit is cleared.

A small register port lets software write the enable bits and clear request bits. Software can never set a request bit. The same port holds the edge polarity of the selectable pins and two source-select bits for shared slots.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the enable register (address 0), request register (address 1) and configuration register (address 2) all read 0, `irqTake` and `setIflag` are 0, and `vecAddr` is 0xFFFC.
- R2: Pins 0, 1, 2, 3 and 4 map to slots 0, 1, 8, 9 and 11. Each sets its request bit on a rising edge when configuration bit g (for pin g) is 1, and on a falling edge when it is 0. The bit is set three clock edges after the pin changes. A held level sets the bit only once, and the opposite edge sets nothing.
- R3: Pin 5 (slot 13) and pin 6 (slot 14 when selected) set their request bits only on a falling edge. A rising edge has no effect.
- R4: A high internal strobe sets its request bit at the same clock edge. The mapping is: bit 0 to slot 2, bit 1 to slot 3, bits 2 to 5 to slots 4 to 7, bit 6 to slot 10, bit 7 to slot 12, bit 8 to slot 14. `brkStb` sets slot 15.
- R5: Writing address 0 loads enable bits 14..0, and bit 15 always reads 0. Writing address 1 ANDs the written data into the request bits. A 0 clears a bit, and a 1 leaves it unchanged, so software can never set a request.
- R6: A maskable slot (0..14) is accepted only at a clock edge where `instrBoundary` is 1, its request bit is 1, its enable bit is 1 and `irqMaskFlag` is 0.
- R7: When several candidates are pending, the lowest slot number wins.
- R8: The vector address for slot s is 0xFFFA − 2·s. Slot 15 (break) therefore gets 0xFFDC.
- R9: A pending break request (slot 15) is accepted at any boundary even when its enable bit is 0 and `irqMaskFlag` is 1. It has the lowest priority among the candidates.
- R10: On acceptance, `irqTake` and `setIflag` are 1 for exactly the one cycle after the boundary edge, and `vecAddr` holds the winner's vector. Only the winner's request bit is cleared. Without a boundary, nothing is taken.
- R11: If a source's event arrives in the same cycle as the acceptance that clears its request, the request stays pending.
- R12: Configuration bit 5 gates internal strobes 0 and 1. When it is 0, those strobes set nothing. Configuration bit 6 selects the source of slot 14: 1 selects internal strobe 8, 0 selects pin 6. The unselected source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 7 | Asynchronous external interrupt pins |
| evtStb | input | 9 | Internal peripheral event strobes |
| brkStb | input | 1 | Software-break strobe from the core |
| regWr | input | 1 | Register write enable |
| regAddr | input | 2 | Register address (0 enable, 1 request, 2 configuration) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` (combinational) |
| instrBoundary | input | 1 | Core is at an instruction boundary; arbitration sample |
| irqMaskFlag | input | 1 | Core's global interrupt-disable flag |
| irqTake | output | 1 | One-cycle strobe: push PC and status, fetch vector |
| setIflag | output | 1 | One-cycle strobe: core sets its disable flag |
| vecAddr | output | 16 | Low-byte address of the accepted vector pair |

## Verification
The acceptance that clears a winner's request bit and a new event for that same source can land on the same clock edge. The bench provokes this by raising the source's internal strobe in the very cycle `instrBoundary` is driven while that source is pending and enabled. It judges the result by checking two things: the take strobe and the correct vector still appear, and reading the request register afterwards shows the bit still set. The priority sweep works across all pairs of slots, including the break slot. After each pair it checks that the loser's bit alone survives the winner's clear.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_SLOT     = 16;
  localparam int SLOT_W       = $clog2(NUM_SLOT);
  localparam int BRK_SLOT     = NUM_SLOT - 1;
  localparam int NUM_MASK     = NUM_SLOT - 1;
  localparam int NUM_EXT      = 7;
  localparam int NUM_SEL_EDGE = 5;
  localparam int NUM_EVT      = 9;
  localparam int DATA_W       = 16;
  localparam int REG_AW       = 2;
  localparam int CFG_W        = NUM_SEL_EDGE + 2;
  localparam int CFG_SER1     = NUM_SEL_EDGE;
  localparam int CFG_CONV     = NUM_SEL_EDGE + 1;

  localparam logic [REG_AW-1:0] ADDR_EN  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_REQ = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CFG = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic              take;
    logic [SLOT_W-1:0] slot;
  } ackCmd_t;
endpackage

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath import vec_irq_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_EVT-1:0]  evtStb,
  input  logic                brkStb,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  ackCmd_t             ackCmd,
  output logic [NUM_SLOT-1:0] reqBits,
  output logic [NUM_MASK-1:0] enBits
);
  logic [NUM_EXT-1:0]  pinLvl;
  logic [NUM_EXT-1:0]  pinPrev;
  logic [NUM_EXT-1:0]  pinRise;
  logic [NUM_EXT-1:0]  pinFall;
  logic [NUM_EXT-1:0]  pinHit;
  logic [NUM_SLOT-1:0] setVec;
  logic [NUM_SLOT-1:0] reqQ;
  logic [NUM_SLOT-1:0] reqNext;
  logic [NUM_MASK-1:0] enQ;
  logic [CFG_W-1:0]    cfgQ;

  // synchronizer chain per pin
  for (genvar g = 0; g < NUM_EXT; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], extPin[g]};
    end
    assign pinLvl[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinLvl;
  end

  assign pinRise = pinLvl & ~pinPrev;
  assign pinFall = ~pinLvl & pinPrev;

  // polarity-selectable pins first, falling-only pins after
  for (genvar g = 0; g < NUM_EXT; g++) begin : gEdge
    if (g < NUM_SEL_EDGE) begin : gSel
      assign pinHit[g] = cfgQ[g] ? pinRise[g] : pinFall[g];
    end else begin : gFall
      assign pinHit[g] = pinFall[g];
    end
  end

  // event to slot routing (slot index is priority order)
  always_comb begin
    setVec       = '0;
    setVec[0]    = pinHit[0];
    setVec[1]    = pinHit[1];
    setVec[2]    = evtStb[0] & cfgQ[CFG_SER1];
    setVec[3]    = evtStb[1] & cfgQ[CFG_SER1];
    setVec[4]    = evtStb[2];
    setVec[5]    = evtStb[3];
    setVec[6]    = evtStb[4];
    setVec[7]    = evtStb[5];
    setVec[8]    = pinHit[2];
    setVec[9]    = pinHit[3];
    setVec[10]   = evtStb[6];
    setVec[11]   = pinHit[4];
    setVec[12]   = evtStb[7];
    setVec[13]   = pinHit[5];
    setVec[14]   = cfgQ[CFG_CONV] ? evtStb[8] : pinHit[6];
    setVec[BRK_SLOT] = brkStb;
  end

  // request register: software clears, acceptance clears, events set last
  always_comb begin
    reqNext = reqQ;
    if (regWr && regAddr == ADDR_REQ) reqNext = reqNext & regWdata[NUM_SLOT-1:0];
    if (ackCmd.take) reqNext[ackCmd.slot] = 1'b0;
    reqNext = reqNext | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= '0;
      enQ  <= '0;
      cfgQ <= '0;
    end else begin
      reqQ <= reqNext;
      if (regWr && regAddr == ADDR_EN)  enQ  <= regWdata[NUM_MASK-1:0];
      if (regWr && regAddr == ADDR_CFG) cfgQ <= regWdata[CFG_W-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_EN:  regRdata = DATA_W'(enQ);
      ADDR_REQ: regRdata = DATA_W'(reqQ);
      ADDR_CFG: regRdata = DATA_W'(cfgQ);
      default:  regRdata = '0;
    endcase
  end

  assign reqBits = reqQ;
  assign enBits  = enQ;
endmodule

// File: rtl/vec_irq_control.sv
module vec_irq_control import vec_irq_pkg::*; #(
  parameter logic [DATA_W-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrBoundary,
  input  logic                irqMaskFlag,
  input  logic [NUM_SLOT-1:0] reqBits,
  input  logic [NUM_MASK-1:0] enBits,
  output ackCmd_t             ackCmd,
  output logic                irqTake,
  output logic                setIflag,
  output logic [DATA_W-1:0]   vecAddr
);
  localparam int PAD_W = DATA_W - SLOT_W - 1;

  logic [NUM_SLOT-1:0] cand;
  logic                anyCand;
  logic [SLOT_W-1:0]   winSlot;
  logic [DATA_W-1:0]   winVec;

  // maskable slots obey enable and global flag; break obeys nothing
  always_comb begin
    cand[NUM_MASK-1:0] = reqBits[NUM_MASK-1:0] & enBits & {NUM_MASK{~irqMaskFlag}};
    cand[BRK_SLOT]     = reqBits[BRK_SLOT];
  end

  // fixed priority: lowest index wins
  always_comb begin
    winSlot = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (cand[i]) winSlot = SLOT_W'(i);
    end
  end

  assign anyCand = |cand;
  assign winVec  = VEC_BASE - {{PAD_W{1'b0}}, winSlot, 1'b0} - DATA_W'(2);

  assign ackCmd.take = instrBoundary & anyCand;
  assign ackCmd.slot = winSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqTake  <= 1'b0;
      setIflag <= 1'b0;
      vecAddr  <= VEC_BASE;
    end else begin
      irqTake  <= ackCmd.take;
      setIflag <= ackCmd.take;
      if (ackCmd.take) vecAddr <= winVec;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl import vec_irq_pkg::*; #(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VEC_BASE    = 16'hFFFC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_EVT-1:0]  evtStb,
  input  logic                brkStb,
  input  logic                regWr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic                instrBoundary,
  input  logic                irqMaskFlag,
  output logic                irqTake,
  output logic                setIflag,
  output logic [DATA_W-1:0]   vecAddr
);
  ackCmd_t             ackCmd;
  logic [NUM_SLOT-1:0] reqBits;
  logic [NUM_MASK-1:0] enBits;

  vec_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .extPin(extPin), .evtStb(evtStb), .brkStb(brkStb),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .ackCmd(ackCmd), .reqBits(reqBits), .enBits(enBits)
  );

  vec_irq_control #(.VEC_BASE(VEC_BASE)) i_control (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .irqMaskFlag(irqMaskFlag),
    .reqBits(reqBits), .enBits(enBits), .ackCmd(ackCmd),
    .irqTake(irqTake), .setIflag(setIflag), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk import vec_irq_pkg::*; (
  input logic                clk,
  input logic                rstN,
  input logic                instrBoundary,
  input logic                irqMaskFlag,
  input logic                irqTake,
  input logic                setIflag,
  input logic [DATA_W-1:0]   vecAddr,
  input logic [NUM_SLOT-1:0] reqBits,
  input logic [NUM_MASK-1:0] enBits
);
  // R10
  take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> ($past(instrBoundary) && setIflag));

  // R10
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrBoundary |=> !irqTake);

  // R6
  masked_no_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && irqMaskFlag && !reqBits[BRK_SLOT]) |=> !irqTake);

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (vecAddr[0] == 1'b0 && vecAddr >= 16'hFFDC && vecAddr <= 16'hFFFA));

  // R9
  brk_unmaskable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && reqBits[BRK_SLOT]) |=> irqTake);

  // R7
  maskable_beats_brk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && !irqMaskFlag && (|(reqBits[NUM_MASK-1:0] & enBits)))
      |=> (irqTake && vecAddr != 16'hFFDC));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk i_chk (
  .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .irqMaskFlag(irqMaskFlag),
  .irqTake(irqTake), .setIflag(setIflag), .vecAddr(vecAddr),
  .reqBits(reqBits), .enBits(enBits)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  extPin = '0;
  logic [8:0]  evtStb = '0;
  logic        brkStb = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        instrBoundary = 1'b0;
  logic        irqMaskFlag = 1'b0;
  logic        irqTake;
  logic        setIflag;
  logic [15:0] vecAddr;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  bit convSelTb = 1'b1;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .evtStb(evtStb), .brkStb(brkStb),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .instrBoundary(instrBoundary), .irqMaskFlag(irqMaskFlag),
    .irqTake(irqTake), .setIflag(setIflag), .vecAddr(vecAddr)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expVec(input int s);
    return 16'hFFFA - 16'(2 * s);
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulsePin(input int p);
    extPin[p] = 1'b1;
    repeat (4) @(negedge clk);
    extPin[p] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseEvt(input int e);
    evtStb[e] = 1'b1;
    @(negedge clk);
    evtStb[e] = 1'b0;
  endtask

  task automatic fireSlot(input int s);
    case (s)
      0:  pulsePin(0);
      1:  pulsePin(1);
      2:  pulseEvt(0);
      3:  pulseEvt(1);
      4:  pulseEvt(2);
      5:  pulseEvt(3);
      6:  pulseEvt(4);
      7:  pulseEvt(5);
      8:  pulsePin(2);
      9:  pulsePin(3);
      10: pulseEvt(6);
      11: pulsePin(4);
      12: pulseEvt(7);
      13: pulsePin(5);
      14: if (convSelTb) pulseEvt(8); else pulsePin(6);
      default: begin brkStb = 1'b1; @(negedge clk); brkStb = 1'b0; end
    endcase
  endtask

  // boundary for one cycle, sample outputs one negedge later
  task automatic accept(output logic t, output logic f, output logic [15:0] v);
    instrBoundary = 1'b1;
    @(negedge clk);
    instrBoundary = 1'b0;
    t = irqTake; f = setIflag; v = vecAddr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        t, f;
    logic [15:0] v;

    repeat (3) @(negedge clk);
    // R1 reset state
    regRead(2'd0, rd); chk("R1 enable", rd, 16'h0);
    regRead(2'd1, rd); chk("R1 request", rd, 16'h0);
    regRead(2'd2, rd); chk("R1 config", rd, 16'h0);
    chk("R1 take", irqTake, 1'b0);
    chk("R1 setIflag", setIflag, 1'b0);
    chk("R1 vecAddr", vecAddr, 16'hFFFC);
    rstN = 1'b1;
    @(negedge clk);

    regWrite(2'd2, 16'h0060);
    regWrite(2'd0, 16'h7FFF);

    // R2 R3 R4 R8 R10 sweep over maskable slots
    for (int s = 0; s < 15; s++) begin
      fireSlot(s);
      regRead(2'd1, rd); chk($sformatf("R2/R3/R4 set slot %0d", s), rd, 32'(1 << s));
      accept(t, f, v);
      chk($sformatf("R10 take slot %0d", s), t, 1'b1);
      chk($sformatf("R10 setIflag slot %0d", s), f, 1'b1);
      chk($sformatf("R8 vector slot %0d", s), v, expVec(s));
      regRead(2'd1, rd); chk($sformatf("R10 cleared slot %0d", s), rd, 16'h0);
      @(negedge clk);
      chk($sformatf("R10 one-cycle slot %0d", s), irqTake, 1'b0);
    end

    // R7 R9 all ordered pairs, break included as lowest
    for (int a = 0; a < 15; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        fireSlot(a);
        fireSlot(b);
        accept(t, f, v);
        chk($sformatf("R7 pair %0d/%0d winner", a, b), v, expVec(a));
        regRead(2'd1, rd); chk($sformatf("R10 pair %0d/%0d loser kept", a, b), rd, 32'(1 << b));
        accept(t, f, v);
        chk($sformatf("R7 pair %0d/%0d second", a, b), v, expVec(b));
        regRead(2'd1, rd); chk($sformatf("R10 pair %0d/%0d empty", a, b), rd, 16'h0);
      end
    end

    // R6 masking
    fireSlot(4);
    irqMaskFlag = 1'b1;
    accept(t, f, v); chk("R6 flag masks", t, 1'b0);
    regRead(2'd1, rd); chk("R6 request kept", rd, 16'h0010);
    irqMaskFlag = 1'b0;
    regWrite(2'd0, 16'h7FEF);
    accept(t, f, v); chk("R6 enable masks", t, 1'b0);
    regWrite(2'd0, 16'h7FFF);
    repeat (3) begin
      @(negedge clk);
      chk("R10 no boundary no take", irqTake, 1'b0);
    end
    accept(t, f, v); chk("R6 accepted when open", t, 1'b1);
    chk("R8 vector slot 4", v, expVec(4));

    // R9 break ignores every mask
    regWrite(2'd0, 16'h0000);
    irqMaskFlag = 1'b1;
    fireSlot(15);
    accept(t, f, v);
    chk("R9 break taken", t, 1'b1);
    chk("R9 break vector", v, 16'hFFDC);
    chk("R9 break setIflag", f, 1'b1);
    irqMaskFlag = 1'b0;

    // R5 software access
    regWrite(2'd0, 16'h1234);
    regRead(2'd0, rd); chk("R5 enable readback", rd, 16'h1234);
    regWrite(2'd0, 16'hFFFF);
    regRead(2'd0, rd); chk("R5 enable bit15 zero", rd, 16'h7FFF);
    regWrite(2'd1, 16'hFFFF);
    regRead(2'd1, rd); chk("R5 cannot set", rd, 16'h0);
    fireSlot(2);
    fireSlot(5);
    regWrite(2'd1, 16'hFFFB);
    regRead(2'd1, rd); chk("R5 clear one bit", rd, 16'h0020);
    regWrite(2'd1, 16'h0000);

    // R11 event in the same cycle as its clear-on-accept
    fireSlot(4);
    instrBoundary = 1'b1;
    evtStb[2] = 1'b1;
    @(negedge clk);
    instrBoundary = 1'b0;
    evtStb[2] = 1'b0;
    chk("R11 take", irqTake, 1'b1);
    chk("R11 vector", vecAddr, expVec(4));
    regRead(2'd1, rd); chk("R11 stays pending", rd, 16'h0010);
    regWrite(2'd1, 16'h0000);

    // R12 shared-slot selects
    regWrite(2'd2, 16'h0000);
    convSelTb = 1'b0;
    pulseEvt(0);
    pulseEvt(1);
    regRead(2'd1, rd); chk("R12 serial gated", rd, 16'h0);
    pulseEvt(8);
    regRead(2'd1, rd); chk("R12 strobe8 unselected", rd, 16'h0);
    fireSlot(14);
    regRead(2'd1, rd); chk("R12 pin6 selected", rd, 16'h4000);
    regWrite(2'd1, 16'h0000);
    regWrite(2'd2, 16'h0040);
    pulsePin(6);
    regRead(2'd1, rd); chk("R12 pin6 unselected", rd, 16'h0);

    // R3 falling-only pins ignore rising even with all polarity bits set
    regWrite(2'd2, 16'h001F);
    extPin[5] = 1'b1;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); chk("R3 rise ignored", rd, 16'h0);
    extPin[5] = 1'b0;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); chk("R3 fall sets", rd, 16'h2000);
    regWrite(2'd1, 16'h0000);

    // R2 rising polarity, latency, one set per held level
    extPin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regRead(2'd1, rd); chk("R2 not before third edge", rd, 16'h0);
    @(negedge clk);
    regRead(2'd1, rd); chk("R2 rise sets at third edge", rd, 16'h0001);
    regWrite(2'd1, 16'h0000);
    repeat (5) @(negedge clk);
    regRead(2'd1, rd); chk("R2 held level once", rd, 16'h0);
    extPin[0] = 1'b0;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); chk("R2 opposite edge ignored", rd, 16'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule